// File: doc/BRIEF.md
# Real-Time Clock Interrupt Event Generator

This block produces the three classic real-time-clock interrupt kinds (update-ended, alarm and periodic) from a shared poll tick. A free-running reference strobe, arriving at the highest supported periodic rate, is divided down inside the block into a poll tick. The poll tick runs at 64 Hz, or at the requested periodic rate when periodic events are enabled and that rate is higher. On every poll tick the block decides which of the enabled event kinds fire. When at least one fires, it latches a 16-bit flag word and raises a one-cycle interrupt pulse.

The time of day arrives on input ports as binary hours, minutes and seconds. Keeping the time is outside this block, and so is producing the reference strobe. Update events are found by noticing that the seconds field has moved since the last update event, not from a hardware update cycle. Periodic events come from counting poll ticks.

Top module: `rtc_evt_gen`

## Requirements
- R1: While reset is asserted and on the first cycle after release, `irq_pulse` is 0 and `irq_flags` is 0.
- R2: While any event kind is enabled, a poll tick occurs every 2^(13-P) reference strobes. P is 6 (64 Hz) unless periodic events are enabled with a rate code above 6, in which case P is that code.
- R3: With periodic events enabled, a periodic event fires on every D-th poll tick, where D = 2^(P-code), or 1 when the code is 6 or more. The divide counter then restarts from zero.
- R4: The periodic rate is 2^code Hz, with `per_code` clamped to the range 1 (2 Hz) to 13 (8192 Hz). A code of 0 acts as 1, and a code above 13 acts as 13.
- R5: An update event fires on a poll tick when update events are enabled and `cur_sec` differs from the seconds value recorded at the last update event. That recorded value then takes `cur_sec`; its reset value is 0.
- R6: An alarm event fires on every poll tick on which alarm events are enabled and hours, minutes and seconds all equal the alarm inputs.
- R7: When an event fires, `irq_flags` takes the following layout on the next cycle and holds it until the next event. Bit 4 marks update, bit 5 alarm, bit 6 periodic, bit 7 is the pending flag (always 1), bits 15:8 hold the count 1, and bits 3:0 are 0.
- R8: `irq_pulse` is high for exactly the one cycle after each poll tick on which at least one event fires, and is low otherwise.
- R9: A rising edge of `en_periodic`, or a change of the clamped rate code, clears the divide counter. On a cycle that clears it, no periodic event fires.
- R10: With all three enables low there are no poll ticks and no pulses. The prescaler is held at zero, so the first poll tick after enabling comes a full poll interval later.
- R11: A kind whose enable is low never sets its flag bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | Reference strobe at the highest periodic rate |
| en_update | input | 1 | Enable update-ended events |
| en_alarm | input | 1 | Enable alarm events |
| en_periodic | input | 1 | Enable periodic events |
| per_code | input | 4 | Periodic rate as log2 of Hz |
| cur_hour | input | 5 | Current hours |
| cur_min | input | 6 | Current minutes |
| cur_sec | input | 6 | Current seconds |
| alm_hour | input | 5 | Alarm hours |
| alm_min | input | 6 | Alarm minutes |
| alm_sec | input | 6 | Alarm seconds |
| irq_pulse | output | 1 | One-cycle interrupt pulse |
| irq_flags | output | 16 | Latched event flag word |

## Verification
The update and alarm kinds can fire on the same poll tick. This happens when the seconds field steps onto the alarm seconds while hours and minutes already match. The bench provokes it with a directed case that moves the seconds from one below the alarm value to the alarm value with both kinds enabled. It expects a single pulse carrying both flag bits, followed by alarm-only pulses while the match persists. Random stimulus over a small time range produces further coincidences, including ones with periodic events. Every pulse is judged against a cycle model in the bench.

// File: rtl/rtc_evt_pkg.sv
package rtc_evt_pkg;

  localparam int FLAG_UPD = 4;
  localparam int FLAG_ALM = 5;
  localparam int FLAG_PER = 6;
  localparam int FLAG_IRQ = 7;

  typedef struct packed {
    logic upd;
    logic alm;
    logic per;
  } evt_t;

  // keep a requested rate code inside the supported band
  function automatic int clamp_code(int code, int lo, int hi);
    if (code < lo) return lo;
    if (code > hi) return hi;
    return code;
  endfunction

  // log2 of the poll rate: the floor rate unless periodic asks for faster
  function automatic int poll_log2(logic per_en, int code, int floor_log2);
    if (per_en && (code > floor_log2)) return code;
    return floor_log2;
  endfunction

  // reference strobes per poll tick
  function automatic int prescale_ratio(int max_log2, int plog2);
    return 1 << (max_log2 - plog2);
  endfunction

  // poll ticks per periodic event
  function automatic int divide_ratio(int plog2, int code);
    if (code >= plog2) return 1;
    return 1 << (plog2 - code);
  endfunction

  function automatic logic [15:0] flag_word(evt_t e);
    logic [15:0] w;
    w = '0;
    w[15:8] = 8'd1;
    w[FLAG_IRQ] = 1'b1;
    w[FLAG_UPD] = e.upd;
    w[FLAG_ALM] = e.alm;
    w[FLAG_PER] = e.per;
    return w;
  endfunction

endpackage

// File: rtl/rtc_poll_timer.sv
module rtc_poll_timer
  import rtc_evt_pkg::*;
#(
  parameter int MAX_LOG2  = 13,
  parameter int BASE_LOG2 = 6,
  parameter int CODE_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              run,
  input  logic              per_en,
  input  logic [CODE_W-1:0] code_eff,
  output logic              poll_tick
);

  localparam int PRE_W = MAX_LOG2 - BASE_LOG2 + 1;

  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] pre_lim;

  always_comb begin
    pre_lim = PRE_W'(prescale_ratio(MAX_LOG2,
                     poll_log2(per_en, int'(code_eff), BASE_LOG2)) - 1);
  end

  // compare with >= so a shrinking limit never strands the count
  assign poll_tick = run & ref_tick & (pre_cnt >= pre_lim);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_cnt <= '0;
    end else if (!run) begin
      pre_cnt <= '0;
    end else if (ref_tick) begin
      pre_cnt <= poll_tick ? '0 : pre_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/rtc_periodic_div.sv
module rtc_periodic_div
  import rtc_evt_pkg::*;
#(
  parameter int BASE_LOG2 = 6,
  parameter int MIN_LOG2  = 1,
  parameter int CODE_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              poll_tick,
  input  logic              per_en,
  input  logic [CODE_W-1:0] code_eff,
  output logic              per_fire,
  output logic              per_clr
);

  localparam int DIV_W = BASE_LOG2 - MIN_LOG2 + 1;

  logic              en_q;
  logic [CODE_W-1:0] code_q;
  logic [DIV_W-1:0]  div_cnt;
  logic [DIV_W-1:0]  div_lim;
  logic [DIV_W:0]    cnt_next;

  always_comb begin
    div_lim = DIV_W'(divide_ratio(poll_log2(1'b1, int'(code_eff), BASE_LOG2),
                                  int'(code_eff)));
  end

  assign cnt_next = {1'b0, div_cnt} + 1'b1;
  assign per_clr  = (per_en & ~en_q) | (code_eff != code_q);
  assign per_fire = poll_tick & per_en & ~per_clr & (cnt_next >= {1'b0, div_lim});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      code_q  <= CODE_W'(MIN_LOG2);
      div_cnt <= '0;
    end else begin
      en_q   <= per_en;
      code_q <= code_eff;
      if (per_clr) begin
        div_cnt <= '0;
      end else if (poll_tick && per_en) begin
        div_cnt <= per_fire ? '0 : cnt_next[DIV_W-1:0];
      end
    end
  end

endmodule

// File: rtl/rtc_event_eval.sv
module rtc_event_eval
  import rtc_evt_pkg::*;
#(
  parameter int HW = 5,
  parameter int MW = 6,
  parameter int SW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          poll_tick,
  input  logic          en_upd,
  input  logic          en_alm,
  input  logic          per_fire,
  input  logic [HW-1:0] cur_hour,
  input  logic [MW-1:0] cur_min,
  input  logic [SW-1:0] cur_sec,
  input  logic [HW-1:0] alm_hour,
  input  logic [MW-1:0] alm_min,
  input  logic [SW-1:0] alm_sec,
  output logic          upd_hit,
  output logic          alm_hit,
  output logic          irq_pulse,
  output logic [15:0]   irq_flags
);

  logic [SW-1:0] last_sec;
  logic          time_match;
  logic          any_hit;
  evt_t          hits;

  assign time_match = (cur_hour == alm_hour) && (cur_min == alm_min) &&
                      (cur_sec == alm_sec);
  assign upd_hit = poll_tick & en_upd & (cur_sec != last_sec);
  assign alm_hit = poll_tick & en_alm & time_match;
  assign any_hit = upd_hit | alm_hit | per_fire;

  always_comb begin
    hits.upd = upd_hit;
    hits.alm = alm_hit;
    hits.per = per_fire;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_sec  <= '0;
      irq_pulse <= 1'b0;
      irq_flags <= '0;
    end else begin
      irq_pulse <= any_hit;
      if (upd_hit) last_sec <= cur_sec;
      if (any_hit) irq_flags <= flag_word(hits);
    end
  end

endmodule

// File: rtl/rtc_evt_gen.sv
module rtc_evt_gen
  import rtc_evt_pkg::*;
#(
  parameter int MAX_LOG2  = 13,
  parameter int BASE_LOG2 = 6,
  parameter int MIN_LOG2  = 1,
  parameter int CODE_W    = 4,
  parameter int HW        = 5,
  parameter int MW        = 6,
  parameter int SW        = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              en_update,
  input  logic              en_alarm,
  input  logic              en_periodic,
  input  logic [CODE_W-1:0] per_code,
  input  logic [HW-1:0]     cur_hour,
  input  logic [MW-1:0]     cur_min,
  input  logic [SW-1:0]     cur_sec,
  input  logic [HW-1:0]     alm_hour,
  input  logic [MW-1:0]     alm_min,
  input  logic [SW-1:0]     alm_sec,
  output logic              irq_pulse,
  output logic [15:0]       irq_flags
);

  logic [CODE_W-1:0] code_eff;
  logic              run;
  logic              poll_tick;
  logic              per_fire;
  logic              per_clr;
  logic              upd_hit;
  logic              alm_hit;

  always_comb begin
    code_eff = CODE_W'(clamp_code(int'(per_code), MIN_LOG2, MAX_LOG2));
  end

  assign run = en_update | en_alarm | en_periodic;

  rtc_poll_timer #(
    .MAX_LOG2 (MAX_LOG2),
    .BASE_LOG2(BASE_LOG2),
    .CODE_W   (CODE_W)
  ) u_poll (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_tick (ref_tick),
    .run      (run),
    .per_en   (en_periodic),
    .code_eff (code_eff),
    .poll_tick(poll_tick)
  );

  rtc_periodic_div #(
    .BASE_LOG2(BASE_LOG2),
    .MIN_LOG2 (MIN_LOG2),
    .CODE_W   (CODE_W)
  ) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .poll_tick(poll_tick),
    .per_en   (en_periodic),
    .code_eff (code_eff),
    .per_fire (per_fire),
    .per_clr  (per_clr)
  );

  rtc_event_eval #(
    .HW(HW),
    .MW(MW),
    .SW(SW)
  ) u_eval (
    .clk      (clk),
    .rst_n    (rst_n),
    .poll_tick(poll_tick),
    .en_upd   (en_update),
    .en_alm   (en_alarm),
    .per_fire (per_fire),
    .cur_hour (cur_hour),
    .cur_min  (cur_min),
    .cur_sec  (cur_sec),
    .alm_hour (alm_hour),
    .alm_min  (alm_min),
    .alm_sec  (alm_sec),
    .upd_hit  (upd_hit),
    .alm_hit  (alm_hit),
    .irq_pulse(irq_pulse),
    .irq_flags(irq_flags)
  );

endmodule

// File: rtl/rtc_evt_chk.sv
module rtc_evt_chk #(
  parameter int HW = 5,
  parameter int MW = 6,
  parameter int SW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en_update,
  input logic          en_alarm,
  input logic          en_periodic,
  input logic [HW-1:0] cur_hour,
  input logic [MW-1:0] cur_min,
  input logic [SW-1:0] cur_sec,
  input logic [HW-1:0] alm_hour,
  input logic [MW-1:0] alm_min,
  input logic [SW-1:0] alm_sec,
  input logic          poll_tick,
  input logic          per_fire,
  input logic          upd_hit,
  input logic          alm_hit,
  input logic          irq_pulse,
  input logic [15:0]   irq_flags
);

  assert_flag_layout_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> (irq_flags[7] && irq_flags[15:8] == 8'd1 && irq_flags[3:0] == 4'd0));

  assert_flag_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_pulse |-> $stable(irq_flags));

  assert_pulse_has_kind_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> (irq_flags[6:4] != 3'd0));

  assert_hit_gives_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_hit || alm_hit || per_fire) |=> irq_pulse);

  assert_idle_no_poll_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_update || en_alarm || en_periodic) |-> !poll_tick);

  assert_alarm_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pulse && irq_flags[5]) |->
      $past(cur_hour == alm_hour && cur_min == alm_min && cur_sec == alm_sec));

  assert_update_enabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pulse && irq_flags[4]) |-> $past(en_update));

  assert_periodic_enabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pulse && irq_flags[6]) |-> $past(en_periodic));

endmodule

bind rtc_evt_gen rtc_evt_chk #(.HW(HW), .MW(MW), .SW(SW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en_update  (en_update),
  .en_alarm   (en_alarm),
  .en_periodic(en_periodic),
  .cur_hour   (cur_hour),
  .cur_min    (cur_min),
  .cur_sec    (cur_sec),
  .alm_hour   (alm_hour),
  .alm_min    (alm_min),
  .alm_sec    (alm_sec),
  .poll_tick  (poll_tick),
  .per_fire   (per_fire),
  .upd_hit    (upd_hit),
  .alm_hit    (alm_hit),
  .irq_pulse  (irq_pulse),
  .irq_flags  (irq_flags)
);

// File: tb/test_rtc_evt_gen.sv
module test_rtc_evt_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic        en_update = 1'b0;
  logic        en_alarm = 1'b0;
  logic        en_periodic = 1'b0;
  logic [3:0]  per_code = 4'd1;
  logic [4:0]  cur_hour = '0;
  logic [5:0]  cur_min = '0;
  logic [5:0]  cur_sec = '0;
  logic [4:0]  alm_hour = '0;
  logic [5:0]  alm_min = '0;
  logic [5:0]  alm_sec = '0;
  logic        irq_pulse;
  logic [15:0] irq_flags;

  int n_chk = 0;
  int n_bad = 0;
  int pcount = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rtc_evt_gen i_rtc_evt_gen (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
    .en_update(en_update), .en_alarm(en_alarm), .en_periodic(en_periodic),
    .per_code(per_code), .cur_hour(cur_hour), .cur_min(cur_min), .cur_sec(cur_sec),
    .alm_hour(alm_hour), .alm_min(alm_min), .alm_sec(alm_sec),
    .irq_pulse(irq_pulse), .irq_flags(irq_flags)
  );

  // reference strobe every second cycle
  always @(negedge clk) ref_tick <= ~ref_tick;

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---- reference model built from the requirements ----
  function automatic int rate_hz(int code);
    int c = code;
    if (c < 1) c = 1;
    if (c > 13) c = 13;
    return 2 ** c;
  endfunction

  int m_pre, m_dc, m_fprev;
  bit m_eprev;
  logic [5:0] m_psec;
  bit m_pulse;
  logic [15:0] m_flags;

  always @(posedge clk) begin
    int fhz, phz, presc, divr;
    bit poll, clr, fu, fa, fp;
    if (!rst_n) begin
      m_pre = 0; m_dc = 0; m_fprev = 2; m_eprev = 0;
      m_psec = 0; m_pulse = 0; m_flags = 0;
    end else begin
      fhz = rate_hz(int'(per_code));
      phz = (en_periodic && fhz > 64) ? fhz : 64;
      presc = 8192 / phz;
      divr = phz / fhz;
      poll = 0;
      if (!(en_update || en_alarm || en_periodic)) m_pre = 0;
      else if (ref_tick) begin
        if (m_pre + 1 >= presc) begin poll = 1; m_pre = 0; end
        else m_pre++;
      end
      clr = (en_periodic && !m_eprev) || (fhz != m_fprev);
      m_eprev = en_periodic;
      m_fprev = fhz;
      fp = 0;
      if (clr) m_dc = 0;
      else if (poll && en_periodic) begin
        if (m_dc + 1 >= divr) begin fp = 1; m_dc = 0; end
        else m_dc++;
      end
      fu = poll && en_update && (cur_sec != m_psec);
      if (fu) m_psec = cur_sec;
      fa = poll && en_alarm && cur_hour == alm_hour && cur_min == alm_min && cur_sec == alm_sec;
      m_pulse = fu | fa | fp;
      if (m_pulse) m_flags = {8'd1, 1'b1, fp, fa, fu, 4'd0};
    end
  end

  // compare every event against the model, away from the clock edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (irq_pulse) pcount++;
      if (irq_pulse || m_pulse)
        check(irq_pulse == m_pulse && irq_flags == m_flags, "R5 R6 R7 R8 R11 model",
              {irq_pulse, irq_flags}, {m_pulse, m_flags});
    end
  end

  task automatic window(int cycles, output int got);
    int start = pcount;
    repeat (cycles) @(negedge clk);
    got = pcount - start;
  endtask

  task automatic wait_pulse(int maxc, output bit seen);
    seen = 0;
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      if (irq_pulse) begin seen = 1; break; end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int got;
    bit seen;
    void'($urandom(32'h1234abcd));
    repeat (5) @(negedge clk);
    check(irq_pulse == 0 && irq_flags == 0, "R1 reset", {irq_pulse, irq_flags}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(irq_pulse == 0 && irq_flags == 0, "R1 after release", {irq_pulse, irq_flags}, 0);

    window(500, got);
    check(got == 0, "R10 idle", got, 0);

    // 2 Hz: one event per 8192 cycles
    per_code = 4'd1; en_periodic = 1'b1;
    window(3 * 8192 + 100, got);
    check(got == 3, "R2 R3 2Hz count", got, 3);
    en_periodic = 1'b0;
    @(negedge clk);

    // code 0 behaves as 2 Hz
    per_code = 4'd0; en_periodic = 1'b1;
    window(3 * 8192 + 100, got);
    check(got == 3, "R4 code0 clamp", got, 3);
    en_periodic = 1'b0;
    @(negedge clk);

    // code 15 behaves as 8192 Hz: every reference strobe
    per_code = 4'd15; en_periodic = 1'b1;
    window(400, got);
    check(got >= 199 && got <= 201, "R2 R4 code15 clamp", got, 200);
    en_periodic = 1'b0;
    @(negedge clk);

    // rate change clears the divide counter
    per_code = 4'd2; en_periodic = 1'b1;
    repeat (3000) @(negedge clk);
    per_code = 4'd3;
    window(1700, got);
    check(got == 0, "R9 no early event after rate change", got, 0);
    window(700, got);
    check(got == 1, "R9 first event after rate change", got, 1);
    en_periodic = 1'b0;
    @(negedge clk);

    // update and alarm on the same poll tick
    alm_hour = 5'd3; alm_min = 6'd4; alm_sec = 6'd5;
    cur_hour = 5'd3; cur_min = 6'd4; cur_sec = 6'd4;
    en_update = 1'b1; en_alarm = 1'b1;
    repeat (600) @(negedge clk);
    cur_sec = 6'd5;
    wait_pulse(400, seen);
    check(seen && irq_flags == 16'h01B0, "R5 R6 R7 coincident", irq_flags, 16'h01B0);
    wait_pulse(400, seen);
    check(seen && irq_flags == 16'h01A0, "R5 R6 alarm repeats, update does not", irq_flags, 16'h01A0);
    alm_min = 6'd9;
    @(negedge clk);
    window(600, got);
    check(got == 0, "R6 mismatch silent", got, 0);

    en_update = 1'b0; en_alarm = 1'b0;
    window(1000, got);
    check(got == 0, "R10 stop", got, 0);

    // constrained random mix
    for (int k = 0; k < 200; k++) begin
      en_update   = $urandom_range(0, 1);
      en_alarm    = $urandom_range(0, 1);
      en_periodic = $urandom_range(0, 2) != 0;
      per_code    = 4'($urandom_range(0, 15));
      cur_hour    = 5'($urandom_range(0, 1));
      cur_min     = 6'($urandom_range(0, 1));
      cur_sec     = 6'($urandom_range(0, 3));
      alm_hour    = 5'($urandom_range(0, 1));
      alm_min     = 6'($urandom_range(0, 1));
      alm_sec     = 6'($urandom_range(0, 3));
      repeat ($urandom_range(50, 500)) @(negedge clk);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule